// File: doc/BRIEF.md
# Bus Status Decoder and Command Generator

This block watches a three-bit bus status code together with a ready input and works out where each bus cycle begins and ends. A cycle begins when the status code leaves the passive value (all ones) while the block is idle. It ends when the code is back at passive and ready is high, which covers both the plain third state and any number of wait states. At the start of a cycle the block samples the code, latches it as the cycle type, raises an address latch pulse for one clock and drives exactly one active-low command strobe for the kind of access being run.

The latched type is held until the end of the cycle, so the strobes stay steady through the third state and the wait states even if the status lines move. A halt code drives no strobe and sets a halt flag instead. A bus that another master has taken floats its status lines to a weak high, so it reads as passive and the block stays quiet.

Top module: `busStatusDecoder`

## Requirements
- R1: In the clock after a cycle start is detected, `cycleType` shows the status code sampled at that start. It holds that code until the end of the cycle and shows 3'b111 at every other time.
- R2: A cycle start is the status moving from 3'b111 in one sampled clock to any other value in the next, while no cycle is open. `ale` is high for exactly the one clock that follows the start and is low at all other times.
- R3: While a cycle is open, the strobe for its code is low and every other strobe is high. The mapping is 3'b000 `intaN`, 3'b001 `ioRdN`, 3'b010 `ioWrN`, 3'b100 `fetchN`, 3'b101 `memRdN` and 3'b110 `memWrN`. At most one strobe is ever low.
- R4: A cycle ends at the first sampled clock in which the status is 3'b111 and `ready` is 1. Its strobe goes high in the clock that follows. While `ready` is 0, a passive status is a wait state and leaves the strobe low.
- R5: While a cycle is open, status changes start no new cycle, raise no `ale`, and leave `cycleType` and the strobes unchanged.
- R6: A halt code (3'b011) opens a cycle that drives no strobe and sets `haltFlag` in the clock after its start. `haltFlag` stays set until a cycle with any other code starts, and then clears in the clock after that start.
- R7: A status held at 3'b111, which is what a floated bus reads as, produces no `ale` and no strobe for any value of `ready`.
- R8: While `rstN` is low, all strobes are high, `ale` and `haltFlag` are low and `cycleType` is 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busStatus | input | 3 | Status code from the bus master |
| ready | input | 1 | High when the addressed device can complete the transfer |
| intaN | output | 1 | Interrupt acknowledge strobe, active low |
| ioRdN | output | 1 | I/O read strobe, active low |
| ioWrN | output | 1 | I/O write strobe, active low |
| fetchN | output | 1 | Code fetch strobe, active low |
| memRdN | output | 1 | Memory read strobe, active low |
| memWrN | output | 1 | Memory write strobe, active low |
| ale | output | 1 | One-clock address latch pulse after a cycle start |
| cycleType | output | 3 | Latched code of the open cycle, 3'b111 when idle |
| haltFlag | output | 1 | Set by a halt cycle |

## Verification
The bench runs a cycle of every code with wait states of zero to three clocks, so that a design ending the cycle on a passive status alone, without looking at ready, releases its strobe early. Cycles are run back to back with no idle clock between them. A design that misses a start when the previous cycle closed in the clock before drops the second cycle. Status lines are changed in the middle of an open cycle, which catches a design that retriggers `ale` or relatches the type. Long passive stretches with ready toggling catch a design that opens cycles out of a floated bus. Halt runs are followed both by another halt and by a real access, which catches a flag that clears at the end of a cycle or never clears.

// File: rtl/busStatusPkg.sv
package busStatusPkg;
  localparam int STATUS_W = 3;
  localparam int NUM_CMD  = 6;

  typedef logic [STATUS_W-1:0] statusT;

  localparam statusT CODE_INTA    = 3'b000;
  localparam statusT CODE_IORD    = 3'b001;
  localparam statusT CODE_IOWR    = 3'b010;
  localparam statusT CODE_HALT    = 3'b011;
  localparam statusT CODE_FETCH   = 3'b100;
  localparam statusT CODE_MEMRD   = 3'b101;
  localparam statusT CODE_MEMWR   = 3'b110;
  localparam statusT CODE_PASSIVE = 3'b111;

  // strobe slot index -> status code that drives it
  function automatic statusT cmdCode(input int idx);
    case (idx)
      0:       return CODE_INTA;
      1:       return CODE_IORD;
      2:       return CODE_IOWR;
      3:       return CODE_FETCH;
      4:       return CODE_MEMRD;
      default: return CODE_MEMWR;
    endcase
  endfunction

  typedef struct packed {
    logic startEv;   // open a cycle at this edge
    logic endEv;     // close the open cycle at this edge
  } ctrlStrobesT;
endpackage

// File: rtl/busCycleCtrl.sv
module busCycleCtrl
  import busStatusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  statusT      busStatus,
  input  logic        ready,
  output ctrlStrobesT ctrl,
  output logic        ale
);
  statusT prevStatus;
  logic   busy;
  logic   isPassive;
  logic   wasPassive;

  assign isPassive  = (busStatus == CODE_PASSIVE);
  assign wasPassive = (prevStatus == CODE_PASSIVE);

  always_comb begin
    ctrl.startEv = !busy && !isPassive && wasPassive;
    ctrl.endEv   = busy && isPassive && ready;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStatus <= CODE_PASSIVE;
      busy       <= 1'b0;
      ale        <= 1'b0;
    end else begin
      prevStatus <= busStatus;
      ale        <= ctrl.startEv;
      if (ctrl.startEv)    busy <= 1'b1;
      else if (ctrl.endEv) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/busCmdDatapath.sv
module busCmdDatapath
  import busStatusPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  statusT             busStatus,
  input  ctrlStrobesT        ctrl,
  output logic [NUM_CMD-1:0] cmdN,
  output statusT             cycleType,
  output logic               haltFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleType <= CODE_PASSIVE;
      haltFlag  <= 1'b0;
    end else begin
      if (ctrl.startEv) begin
        cycleType <= busStatus;
        haltFlag  <= (busStatus == CODE_HALT);
      end else if (ctrl.endEv) begin
        cycleType <= CODE_PASSIVE;
      end
    end
  end

  for (genvar g = 0; g < NUM_CMD; g++) begin : gStrobe
    localparam statusT MY_CODE = cmdCode(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             cmdN[g] <= 1'b1;
      else if (ctrl.startEv) cmdN[g] <= (busStatus != MY_CODE);
      else if (ctrl.endEv)   cmdN[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/busStatusDecoder.sv
module busStatusDecoder
  import busStatusPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] busStatus,
  input  logic       ready,
  output logic       intaN,
  output logic       ioRdN,
  output logic       ioWrN,
  output logic       fetchN,
  output logic       memRdN,
  output logic       memWrN,
  output logic       ale,
  output logic [2:0] cycleType,
  output logic       haltFlag
);
  ctrlStrobesT        ctrl;
  logic [NUM_CMD-1:0] cmdN;

  busCycleCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busStatus(busStatus), .ready(ready),
    .ctrl(ctrl), .ale(ale)
  );

  busCmdDatapath uData (
    .clk(clk), .rstN(rstN), .busStatus(busStatus), .ctrl(ctrl),
    .cmdN(cmdN), .cycleType(cycleType), .haltFlag(haltFlag)
  );

  assign intaN  = cmdN[0];
  assign ioRdN  = cmdN[1];
  assign ioWrN  = cmdN[2];
  assign fetchN = cmdN[3];
  assign memRdN = cmdN[4];
  assign memWrN = cmdN[5];
endmodule

// File: rtl/busStatusDecoderChk.sv
module busStatusDecoderChk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] busStatus,
  input logic       ready,
  input logic       intaN,
  input logic       ioRdN,
  input logic       ioWrN,
  input logic       fetchN,
  input logic       memRdN,
  input logic       memWrN,
  input logic       ale,
  input logic [2:0] cycleType,
  input logic       haltFlag
);
  logic [5:0] cmds;
  assign cmds = {memWrN, memRdN, fetchN, ioWrN, ioRdN, intaN};

  a_r2_ale_single_clock: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  a_r2_ale_after_departure: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> $past(busStatus) != 3'b111);
  a_r1_type_from_start: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> cycleType == $past(busStatus));
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~cmds) <= 1);
  a_r5_type_held: assert property (@(posedge clk) disable iff (!rstN)
    (cycleType != 3'b111 && !(busStatus == 3'b111 && ready)) |=> $stable(cycleType));
  a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cycleType == 3'b011) |-> (&cmds && haltFlag));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cycleType == 3'b111) |-> &cmds);
endmodule

bind busStatusDecoder busStatusDecoderChk uChk (
  .clk(clk), .rstN(rstN), .busStatus(busStatus), .ready(ready),
  .intaN(intaN), .ioRdN(ioRdN), .ioWrN(ioWrN), .fetchN(fetchN),
  .memRdN(memRdN), .memWrN(memWrN), .ale(ale), .cycleType(cycleType),
  .haltFlag(haltFlag)
);

// File: tb/tb_busStatusDecoder.sv
module tb_busStatusDecoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busStatus = 3'b111;
  logic       ready = 1'b1;
  logic intaN, ioRdN, ioWrN, fetchN, memRdN, memWrN, ale, haltFlag;
  logic [2:0] cycleType;

  busStatusDecoder dut (
    .clk(clk), .rstN(rstN), .busStatus(busStatus), .ready(ready),
    .intaN(intaN), .ioRdN(ioRdN), .ioWrN(ioWrN), .fetchN(fetchN),
    .memRdN(memRdN), .memWrN(memWrN), .ale(ale), .cycleType(cycleType),
    .haltFlag(haltFlag)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string phase  = "R8";

  // behavioural reference: expected outputs after the latest edge
  bit       mOpen = 0;
  int       mPrev = 7;
  int       mType = 7;
  bit       mAle  = 0;
  bit       mHalt = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mOpen = 0; mPrev = 7; mType = 7; mAle = 0; mHalt = 0;
    end else begin
      int s;
      s = int'(busStatus);
      mAle = 0;
      if (!mOpen && s != 7 && mPrev == 7) begin
        mOpen = 1; mType = s; mAle = 1; mHalt = (s == 3);
      end else if (mOpen && s == 7 && ready) begin
        mOpen = 0; mType = 7;
      end
      mPrev = s;
    end
  end

  function automatic bit expLow(int code);
    return (mType == code) && code != 3 && code != 7;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) %s: actual %0d expected %0d at cycle %0d",
               req, phase, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk("R2", "ale", int'(ale), int'(mAle));
    chk("R1", "cycleType", int'(cycleType), mType);
    chk("R6", "haltFlag", int'(haltFlag), int'(mHalt));
    chk("R3", "intaN",  int'(intaN),  int'(!expLow(0)));
    chk("R3", "ioRdN",  int'(ioRdN),  int'(!expLow(1)));
    chk("R3", "ioWrN",  int'(ioWrN),  int'(!expLow(2)));
    chk("R4", "fetchN", int'(fetchN), int'(!expLow(4)));
    chk("R4", "memRdN", int'(memRdN), int'(!expLow(5)));
    chk("R4", "memWrN", int'(memWrN), int'(!expLow(6)));
  end

  task automatic step(int s, bit r);
    @(negedge clk);
    busStatus = 3'(s);
    ready = r;
  endtask

  // one bus cycle: status held two clocks, then passive with waits
  task automatic busCycle(int code, int waits, bit wiggle);
    step(code, 1);
    step(wiggle ? (code ^ 5) : code, 1);   // R5: mid-cycle change
    for (int w = 0; w < waits; w++) step(7, 0);
    step(7, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R8";
    chk("R8", "reset ale", int'(ale), 0);
    chk("R8", "reset type", int'(cycleType), 7);
    chk("R8", "reset strobes", int'({intaN, ioRdN, ioWrN, fetchN, memRdN, memWrN}), 63);
    rstN = 1'b1;
    step(7, 1); step(7, 1);

    phase = "R3";
    for (int c = 0; c < 7; c++) begin
      busCycle(c, 0, 0);
      step(7, 1);
    end
    phase = "R4";
    for (int w = 1; w < 4; w++) begin
      busCycle(5, w, 0);
      busCycle(6, w, 0);
      step(7, 1);
    end
    phase = "R2";
    busCycle(4, 0, 0); busCycle(5, 1, 0); busCycle(1, 0, 0); busCycle(0, 2, 0);
    step(7, 1);
    phase = "R5";
    busCycle(1, 1, 1); busCycle(6, 0, 1); busCycle(4, 2, 1);
    step(7, 1);
    phase = "R7";
    for (int i = 0; i < 12; i++) step(7, i[0]);
    phase = "R6";
    busCycle(3, 0, 0); step(7, 1);
    busCycle(3, 1, 0); step(7, 1);
    busCycle(2, 0, 0); step(7, 1);
    busCycle(3, 0, 0); busCycle(0, 0, 0);
    repeat (4) step(7, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule